// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter in a peripheral of a small controller. Software writes the GO bit to start a conversion. The sequencer then releases the sample-and-hold from tracking and waits a short start delay. The delay is longer when the conversion clock comes from the free-running RC source. After the delay the sequencer resolves one result bit per conversion clock period. It works from the most significant bit down, drives a trial code to an external DAC and reads back an external comparator.

When the least significant bit is decided, three things happen in the same clock cycle: the result register takes the new value, the interrupt flag rises, and GO drops. The sequencer then waits one and a half conversion clock periods before it lets the sample-and-hold track again. The conversion clock reaches the block as an enable input, `tad_half`, which pulses once per half period. A full period is therefore two pulses. The comparator, the DAC and the sample-and-hold are outside the block.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `sample_en` is 1, and `go`, `irq_flag`, `result` and `dac_code` are all 0.
- R2: A `go_set` pulse while sampling sets `go` to 1 and clears `sample_en` on the next clock edge.
- R3: With `src_rc`=0, the trial code first reads 0x80 exactly DLY_DRV (default 1) clock edges after the edge that accepted `go_set`. With `src_rc`=1 this takes DLY_DRV+INSTR_CYC (default 5) edges.
- R4: Each approximation step consumes two `tad_half` pulses. A step first drives the current bit as 1 in `dac_code`. It keeps that bit when `cmp_hi`=1 (input at or above the DAC level) and clears it otherwise. The sweep runs from bit 7 to bit 0 and takes 16 pulses in all. With an ideal comparator, the result equals the input code.
- R5: On the clock edge that completes a conversion, `result` takes the new code, `irq_flag` becomes 1 and `go` becomes 0.
- R6: `result` keeps its previous value for the whole of a conversion.
- R7: After completion, `sample_en` returns to 1 on the edge of the third following `tad_half` pulse, which is 1.5 conversion clock periods. It stays 0 until then.
- R8: `irq_flag` stays 1 until a `flag_clr` pulse clears it.
- R9: A `go_set` pulse during a conversion or its start delay neither restarts nor lengthens the conversion.
- R10: A `go_clr` pulse during the start delay or a conversion aborts it. `go` drops, `result` and `irq_flag` are left unchanged, and sampling resumes after the 1.5-period switch-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tad_half | input | 1 | Enable pulse once per conversion-clock half period |
| src_rc | input | 1 | Conversion clock source: 1 = RC, 0 = derived from the oscillator |
| go_set | input | 1 | Software write of GO = 1 |
| go_clr | input | 1 | Software write of GO = 0 |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 8 | Trial code to the DAC (0 outside conversion) |
| sample_en | output | 1 | Sample-and-hold tracks when 1 |
| go | output | 1 | GO bit, 1 while a conversion is pending or running |
| result | output | 8 | Result register |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The input codes tried are all zeros, all ones, the two codes on either side of mid-scale (0x80 and 0x7F), an alternating pattern and an irregular code. All-zeros and all-ones catch an inverted keep/clear decision. The mid-scale pair catches a slip at the first decided bit, and the alternating and irregular codes catch a bit-order or shift error. The tests alternate between the two clock sources, so the measured start latency separates the two delays. Each conversion also has a redundant GO write in the middle, and one directed abort checks that the result and the flag are left untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Phases of the sequencer
    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_DELAY  = 2'd1,
        ST_CONV   = 2'd2,
        ST_SWITCH = 2'd3
    } seq_phase_e;

    // Control strobes from the sequencer to the approximation register
    typedef struct packed {
        logic start;
        logic step;
        logic clear;
    } sar_ctl_t;

    // Bit left in the code after one decision
    function automatic logic [7:0] decide_bit(input logic [7:0] code,
                                              input logic [7:0] mask,
                                              input logic       keep);
        return keep ? code : (code & ~mask);
    endfunction

endpackage

// File: rtl/adc_start_timer.sv
module adc_start_timer #(
    parameter int DLY_DRV   = 1,
    parameter int INSTR_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic src_rc,
    input  logic cancel,
    output logic expired
);
    localparam int DLY_MAX = DLY_DRV + INSTR_CYC;
    localparam int CW      = $clog2(DLY_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign expired = run_q && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= src_rc ? CW'(DLY_MAX) : CW'(DLY_DRV);
            run_q <= 1'b1;
        end else if (cancel || expired) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R3: a running timer never counts past zero
    a_r3_timer_nonzero: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q != '0));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sar_ctl_t     ctl,
    input  logic         cmp_hi,
    output logic [W-1:0] code,
    output logic         last,
    output logic [W-1:0] final_code
);
    logic [W-1:0] code_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] kept;

    always_comb begin
        kept = code_q;
        if (W == 8) begin
            kept = W'(decide_bit(8'(code_q), 8'(mask_q), cmp_hi));
        end else if (!cmp_hi) begin
            kept = code_q & ~mask_q;
        end
    end

    assign code       = code_q;
    assign last       = mask_q[0];
    assign final_code = kept;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (ctl.start) begin
            code_q <= W'(1) << (W - 1);
            mask_q <= W'(1) << (W - 1);
        end else if (ctl.step) begin
            if (mask_q[0]) begin
                code_q <= '0;
                mask_q <= '0;
            end else begin
                code_q <= kept | (mask_q >> 1);
                mask_q <= mask_q >> 1;
            end
        end
    end

    // R4: exactly one trial bit at most is under test
    a_r4_mask_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q));

    // R4: bits below the trial bit are zero while a trial is active
    a_r4_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
        (mask_q != '0) |-> ((code_q & (mask_q - W'(1))) == '0));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int W         = 8,
    parameter int DLY_DRV   = 1,
    parameter int INSTR_CYC = 4,
    parameter int SW_HALVES = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tad_half,
    input  logic         src_rc,
    input  logic         go_set,
    input  logic         go_clr,
    input  logic         flag_clr,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_code,
    output logic         sample_en,
    output logic         go,
    output logic [W-1:0] result,
    output logic         irq_flag
);
    localparam int SWW = $clog2(SW_HALVES + 1);

    seq_phase_e   state_q;
    logic         go_q;
    logic         irq_q;
    logic [W-1:0] result_q;
    logic         half_ph_q;
    logic [SWW-1:0] sw_cnt_q;

    sar_ctl_t     ctl;
    logic         tmr_load;
    logic         tmr_cancel;
    logic         tmr_expired;
    logic         sar_last;
    logic [W-1:0] sar_final;
    logic         done;
    logic         abort;

    assign abort      = go_clr && ((state_q == ST_DELAY) || (state_q == ST_CONV));
    assign tmr_load   = (state_q == ST_SAMPLE) && go_set && !go_clr;
    assign tmr_cancel = abort;
    assign done       = (state_q == ST_CONV) && !go_clr && tad_half && half_ph_q && sar_last;

    always_comb begin
        ctl.start = (state_q == ST_DELAY) && !go_clr && tmr_expired;
        ctl.step  = (state_q == ST_CONV) && !go_clr && tad_half && half_ph_q;
        ctl.clear = abort;
    end

    adc_start_timer #(
        .DLY_DRV  (DLY_DRV),
        .INSTR_CYC(INSTR_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .src_rc (src_rc),
        .cancel (tmr_cancel),
        .expired(tmr_expired)
    );

    adc_sar_core #(.W(W)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .cmp_hi    (cmp_hi),
        .code      (dac_code),
        .last      (sar_last),
        .final_code(sar_final)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_SAMPLE;
            go_q      <= 1'b0;
            half_ph_q <= 1'b0;
            sw_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_SAMPLE: begin
                    if (tmr_load) begin
                        go_q    <= 1'b1;
                        state_q <= ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (go_clr) begin
                        go_q     <= 1'b0;
                        sw_cnt_q <= '0;
                        state_q  <= ST_SWITCH;
                    end else if (tmr_expired) begin
                        half_ph_q <= 1'b0;
                        state_q   <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (go_clr) begin
                        go_q     <= 1'b0;
                        sw_cnt_q <= '0;
                        state_q  <= ST_SWITCH;
                    end else if (tad_half) begin
                        half_ph_q <= ~half_ph_q;
                        if (done) begin
                            go_q     <= 1'b0;
                            sw_cnt_q <= '0;
                            state_q  <= ST_SWITCH;
                        end
                    end
                end
                ST_SWITCH: begin
                    if (tad_half) begin
                        if (sw_cnt_q == SWW'(SW_HALVES - 1)) begin
                            state_q <= ST_SAMPLE;
                        end else begin
                            sw_cnt_q <= sw_cnt_q + SWW'(1);
                        end
                    end
                end
                default: state_q <= ST_SAMPLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            irq_q    <= 1'b0;
        end else if (done) begin
            result_q <= sar_final;
            irq_q    <= 1'b1;
        end else if (flag_clr) begin
            irq_q    <= 1'b0;
        end
    end

    assign sample_en = (state_q == ST_SAMPLE);
    assign go        = go_q;
    assign result    = result_q;
    assign irq_flag  = irq_q;

    // R2: sampling is stopped whenever GO is pending
    a_r2_go_stops_sample: assert property (@(posedge clk) disable iff (rst)
        go_q |-> !sample_en);

    // R5: the flag rises only together with GO dropping
    a_r5_flag_with_go_low: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> (!go_q && $past(state_q) == ST_CONV));

    // R6: result is frozen while converting
    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && $past(state_q) == ST_CONV) |-> $stable(result_q));

    // R8: the flag holds until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_q) && !$past(flag_clr)) |-> irq_q);

    // R10: an abort leaves result and flag untouched
    a_r10_abort_clean: assert property (@(posedge clk) disable iff (rst)
        ($past(go_clr) && $past(state_q) == ST_CONV) |->
            (!go_q && $stable(result_q) && !$rose(irq_q)));

endmodule

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tad_half = 1'b0;
    logic       src_rc = 1'b0;
    logic       go_set = 1'b0;
    logic       go_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cmp_hi;
    logic [7:0] dac_code;
    logic       sample_en;
    logic       go;
    logic [7:0] result;
    logic       irq_flag;
    logic [7:0] vin = 8'h00;

    int checks = 0;
    int fails  = 0;

    // stimulus table: {input code, clock source}
    localparam logic [8:0] VEC [6] = '{
        {8'h00, 1'b0}, {8'hFF, 1'b1}, {8'h80, 1'b0},
        {8'h7F, 1'b1}, {8'h55, 1'b0}, {8'hA3, 1'b1}
    };

    always #2.5 clk = ~clk;

    // ideal comparator
    assign cmp_hi = (vin >= dac_code);

    adc_seq_top dut_i (
        .clk(clk), .rst(rst), .tad_half(tad_half), .src_rc(src_rc),
        .go_set(go_set), .go_clr(go_clr), .flag_clr(flag_clr), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .sample_en(sample_en), .go(go),
        .result(result), .irq_flag(irq_flag)
    );

    // half-period enable generator, driven just after each rising edge
    initial begin
        int k = 0;
        forever begin
            @(posedge clk);
            #1;
            tad_half = (k % HALF) == (HALF - 1);
            k++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_go_set();
        @(negedge clk); go_set = 1'b1;
        @(negedge clk); go_set = 1'b0;
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        int lat, pulses, guard;
        bit stable_ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sample_en == 1'b1, "R1 sample_en", sample_en, 1);
        chk(go == 1'b0, "R1 go", go, 0);
        chk(irq_flag == 1'b0, "R1 irq_flag", irq_flag, 0);
        chk(result == 8'h00, "R1 result", result, 0);
        chk(dac_code == 8'h00, "R1 dac_code", dac_code, 0);

        foreach (VEC[i]) begin
            vin    = VEC[i][8:1];
            src_rc = VEC[i][0];
            prev   = result;
            pulse_go_set();
            // R2: GO set, sampling stopped
            chk(go == 1'b1, "R2 go", go, 1);
            chk(sample_en == 1'b0, "R2 sample_en", sample_en, 0);
            lat = 0;
            while (dac_code != 8'h80 && lat < 50) begin
                @(negedge clk);
                lat++;
            end
            // R3: start delay depends on the source
            chk(lat == (src_rc ? 5 : 1), "R3 start latency", lat, src_rc ? 5 : 1);
            pulses = 0;
            stable_ok = 1'b1;
            guard = 0;
            while (!irq_flag && guard < 500) begin
                if (result != prev || sample_en) stable_ok = 1'b0;
                go_set = (pulses == 5);   // R9: redundant GO write mid-conversion
                if (tad_half) pulses++;
                @(negedge clk);
                guard++;
            end
            go_set = 1'b0;
            // R4: 16 half-period pulses and a correct code
            chk(pulses == 16, "R4/R9 pulse count", pulses, 16);
            chk(result == vin, "R4 result code", result, vin);
            // R5: result, flag and GO together
            chk(go == 1'b0, "R5 go cleared", go, 0);
            chk(irq_flag == 1'b1, "R5 flag set", irq_flag, 1);
            // R6: result held during conversion
            chk(stable_ok, "R6 result held", stable_ok, 1);
            pulses = 0;
            guard = 0;
            while (!sample_en && guard < 200) begin
                if (tad_half) pulses++;
                @(negedge clk);
                guard++;
            end
            // R7: switch back after three half periods
            chk(pulses == 3, "R7 switch-back pulses", pulses, 3);
            repeat (4) @(negedge clk);
            // R8: flag still set until cleared
            chk(irq_flag == 1'b1, "R8 flag held", irq_flag, 1);
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
            chk(irq_flag == 1'b0, "R8 flag cleared", irq_flag, 0);
        end

        // R10: abort in the middle of a conversion
        vin    = 8'h3C;
        src_rc = 1'b0;
        prev   = result;
        pulse_go_set();
        pulses = 0;
        while (pulses < 5) begin
            if (tad_half) pulses++;
            @(negedge clk);
        end
        go_clr = 1'b1;
        @(negedge clk);
        go_clr = 1'b0;
        chk(go == 1'b0, "R10 go dropped", go, 0);
        chk(irq_flag == 1'b0, "R10 no flag", irq_flag, 0);
        chk(sample_en == 1'b0, "R10 switch-back pending", sample_en, 0);
        guard = 0;
        while (!sample_en && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(sample_en == 1'b1, "R10 sampling resumed", sample_en, 1);
        chk(result == prev, "R10 result kept", result, prev);
        chk(irq_flag == 1'b0, "R10 flag still clear", irq_flag, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule